// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates addresses for one port of a synchronous memory. It holds four registers: an address counter, a mask that limits which counter bits may move, a mirror that remembers the last loaded start address, and a busy-address register that captures the current address on request. Each clock it performs at most one counter operation and at most one mask operation, chosen from request inputs by a fixed priority.

The mask confines counting to a contiguous field of address bits. Bits above the field stay frozen, so the counter wraps inside a sub-range. Up to two frozen bits below the field make the address step by 2 or 4. When an increment passes the top of the field, a one-cycle active-low interrupt flags the wrap. A mask whose pattern does not fit these rules is refused, and an error pulse reports the refusal.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, and after a master-reset request, the address, mirror and busy address are 0, the mask is all ones, the interrupt is high and the error flag is low.
- R2: Counter requests resolve with priority master reset, then counter reset, then load, then retransmit, then increment. Only the winner takes effect.
- R3: Load writes `addr_i` into the counter and the mirror. Retransmit copies the mirror into the counter.
- R4: A mask load is accepted only if the pattern, read from bit 0 upward, is zero, one or two 0 bits, then one or more 1 bits, then only 0 bits. A refused load keeps the old mask and drives `msk_err_o` high for the cycle after it. Otherwise `msk_err_o` is low.
- R5: Mask reset sets the mask to all ones. Mask operations never change the counter, and counter operations never change the mask.
- R6: Counter reset clears the counter bits where the mask is 1 and keeps the bits where it is 0.
- R7: Increment adds one to the field of counter bits under the mask's 1s. The field wraps to zero on overflow, and bits under the mask's 0s never change. The address therefore steps by 1, 2 or 4 when the mask ends in binary 1, 10 or 00.
- R8: `cnt_irq_n_o` is low for exactly the cycle after an increment that finds every unmasked counter bit at 1. It is high at all other times.
- R9: `busy_cap_i` copies the pre-update counter into the busy-address register. Master reset clears that register.
- R10: With no counter request, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mrst_i | input | 1 | Master-reset request |
| cnt_rst_i | input | 1 | Counter-reset request |
| cnt_load_i | input | 1 | Counter-load request |
| retx_i | input | 1 | Retransmit request |
| cnt_inc_i | input | 1 | Increment request |
| msk_rst_i | input | 1 | Mask-reset request |
| msk_load_i | input | 1 | Mask-load request |
| busy_cap_i | input | 1 | Capture the current address into the busy register |
| addr_i | input | AW | Address bus for counter and mask loads |
| addr_o | output | AW | Current counter address |
| mask_o | output | AW | Current mask |
| busy_addr_o | output | AW | Busy-address register |
| cnt_irq_n_o | output | 1 | Active-low wrap interrupt |
| msk_err_o | output | 1 | Refused mask-load pulse |

## Verification
On every cycle, the assertions check that masked bits are frozen across increments, that counter reset clears only the unmasked field, that a load makes the mirror equal the counter, and that a low interrupt follows a wrap to zero. They also check that a refused mask leaves the mask unchanged, that mask reset gives all ones, and that a mask-only cycle leaves the address alone. Only the bench scenarios show the full behaviour over time. These cover the exact accept or refuse decision for every mask pattern, the full increment sequence and wrap point under every legal mask, the priority resolution, retransmit after many steps, and busy capture.

// File: rtl/bac_pkg.sv
package bac_pkg;

  typedef enum logic [2:0] {
    CNT_HOLD,
    CNT_MRST,
    CNT_CLR,
    CNT_LOAD,
    CNT_RETX,
    CNT_INC
  } cnt_op_e;

  typedef enum logic [1:0] {
    MSK_HOLD,
    MSK_MRST,
    MSK_SET,
    MSK_LOAD
  } msk_op_e;

endpackage

// File: rtl/bac_mask_reg.sv
module bac_mask_reg
  import bac_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  msk_op_e       op_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] mask_o,
  output logic          err_o
);

  // pattern: up to two low 0s, one run of 1s, then 0s only
  function automatic logic pattern_ok(input logic [AW-1:0] m);
    logic [AW-1:0] rest;
    if (m == '0) return 1'b0;
    if (m[2:0] == 3'b000) return 1'b0;
    rest = m[0] ? m : (m[1] ? (m >> 1) : (m >> 2));
    return ((rest & (rest + 1'b1)) == '0);
  endfunction

  logic [AW-1:0] mask_q, mask_d;
  logic          mask_en;
  logic          err_q, err_d;
  logic          load_ok;

  always_comb begin
    load_ok = pattern_ok(addr_i);
    mask_d  = mask_q;
    mask_en = 1'b0;
    err_d   = 1'b0;
    unique case (op_i)
      MSK_MRST, MSK_SET: begin
        mask_d  = '1;
        mask_en = 1'b1;
      end
      MSK_LOAD: begin
        mask_d  = addr_i;
        mask_en = load_ok;
        err_d   = !load_ok;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      err_q  <= 1'b0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      err_q <= err_d;
    end
  end

  assign mask_o = mask_q;
  assign err_o  = err_q;

  AST_BAD_MASK_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == MSK_LOAD) && !pattern_ok(addr_i) |=> $stable(mask_o) && err_o); // R4

  AST_MASK_SET_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == MSK_SET) |=> (mask_o == '1)); // R5

endmodule

// File: rtl/bac_counter.sv
module bac_counter
  import bac_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cnt_op_e       op_i,
  input  logic [AW-1:0] mask_i,
  input  logic [AW-1:0] addr_i,
  input  logic          busy_cap_i,
  input  logic          mrst_i,
  output logic [AW-1:0] cnt_o,
  output logic [AW-1:0] busy_o,
  output logic          irq_n_o
);

  logic [AW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] mir_q, mir_d;
  logic [AW-1:0] busy_q, busy_d;
  logic          cnt_en, mir_en, busy_en;
  logic          irq_n_q, irq_n_d;
  logic [AW-1:0] step;
  logic [AW-1:0] inc_val;
  logic          at_top;

  always_comb begin
    step    = mask_i & (~mask_i + 1'b1);
    inc_val = (cnt_q & ~mask_i) | ((cnt_q + step) & mask_i);
    at_top  = ((cnt_q & mask_i) == mask_i);

    cnt_d   = cnt_q;
    mir_d   = mir_q;
    cnt_en  = 1'b1;
    mir_en  = 1'b0;
    irq_n_d = 1'b1;
    unique case (op_i)
      CNT_MRST: begin
        cnt_d  = '0;
        mir_d  = '0;
        mir_en = 1'b1;
      end
      CNT_CLR:  cnt_d = cnt_q & ~mask_i;
      CNT_LOAD: begin
        cnt_d  = addr_i;
        mir_d  = addr_i;
        mir_en = 1'b1;
      end
      CNT_RETX: cnt_d = mir_q;
      CNT_INC: begin
        cnt_d   = inc_val;
        irq_n_d = !at_top;
      end
      default: cnt_en = 1'b0;
    endcase

    busy_en = mrst_i || busy_cap_i;
    busy_d  = mrst_i ? '0 : cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      mir_q   <= '0;
      busy_q  <= '0;
      irq_n_q <= 1'b1;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (mir_en)  mir_q  <= mir_d;
      if (busy_en) busy_q <= busy_d;
      irq_n_q <= irq_n_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign busy_o  = busy_q;
  assign irq_n_o = irq_n_q;

  AST_MASKED_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == CNT_INC) |=> ((cnt_o & ~$past(mask_i)) == ($past(cnt_o) & ~$past(mask_i)))); // R7

  AST_CLR_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == CNT_CLR) |=> ((cnt_o & $past(mask_i)) == '0)); // R6

  AST_LOAD_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == CNT_LOAD) |=> (mir_q == cnt_o)); // R3

  AST_IRQ_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_n_o |-> ((cnt_o & $past(mask_i)) == '0)); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == CNT_HOLD) |=> $stable(cnt_o)); // R10

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bac_pkg::*;
#(
  parameter int AW          = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mrst_i,
  input  logic          cnt_rst_i,
  input  logic          cnt_load_i,
  input  logic          retx_i,
  input  logic          cnt_inc_i,
  input  logic          msk_rst_i,
  input  logic          msk_load_i,
  input  logic          busy_cap_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] mask_o,
  output logic [AW-1:0] busy_addr_o,
  output logic          cnt_irq_n_o,
  output logic          msk_err_o
);

  localparam int SyncMsb = SYNC_STAGES - 1;

  // asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_sync_n;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rst_sync_q <= '0;
        else         rst_sync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rst_sync_q <= '0;
        else         rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = rst_sync_q[SyncMsb];

  cnt_op_e cnt_op;
  msk_op_e msk_op;

  always_comb begin
    if      (mrst_i)     cnt_op = CNT_MRST;
    else if (cnt_rst_i)  cnt_op = CNT_CLR;
    else if (cnt_load_i) cnt_op = CNT_LOAD;
    else if (retx_i)     cnt_op = CNT_RETX;
    else if (cnt_inc_i)  cnt_op = CNT_INC;
    else                 cnt_op = CNT_HOLD;

    if      (mrst_i)     msk_op = MSK_MRST;
    else if (msk_rst_i)  msk_op = MSK_SET;
    else if (msk_load_i) msk_op = MSK_LOAD;
    else                 msk_op = MSK_HOLD;
  end

  bac_mask_reg #(.AW(AW)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .op_i   (msk_op),
    .addr_i (addr_i),
    .mask_o (mask_o),
    .err_o  (msk_err_o)
  );

  bac_counter #(.AW(AW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .op_i       (cnt_op),
    .mask_i     (mask_o),
    .addr_i     (addr_i),
    .busy_cap_i (busy_cap_i),
    .mrst_i     (mrst_i),
    .cnt_o      (addr_o),
    .busy_o     (busy_addr_o),
    .irq_n_o    (cnt_irq_n_o)
  );

  AST_MASK_NO_CNT: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (cnt_op == CNT_HOLD) && (msk_op != MSK_HOLD) |=> $stable(addr_o)); // R5

  AST_MRST_STATE: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    mrst_i |=> (addr_o == '0) && (mask_o == '1) && (busy_addr_o == '0)); // R1

endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

  localparam int AW = 6;
  localparam int N  = 1 << AW;
  localparam logic [AW-1:0] ONES = '1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mrst, crst, cload, retx, cinc, mrst_m, mload, bcap;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out, mask_out, busy_out;
  logic          irq_n, merr;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  burst_addr_gen #(.AW(AW)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mrst_i      (mrst),
    .cnt_rst_i   (crst),
    .cnt_load_i  (cload),
    .retx_i      (retx),
    .cnt_inc_i   (cinc),
    .msk_rst_i   (mrst_m),
    .msk_load_i  (mload),
    .busy_cap_i  (bcap),
    .addr_i      (addr_in),
    .addr_o      (addr_out),
    .mask_o      (mask_out),
    .busy_addr_o (busy_out),
    .cnt_irq_n_o (irq_n),
    .msk_err_o   (merr)
  );

  task automatic clr_in();
    mrst = 0; crst = 0; cload = 0; retx = 0; cinc = 0;
    mrst_m = 0; mload = 0; bcap = 0; addr_in = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    clr_in();
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference rule, scanned from bit 0 upward
  function automatic bit valid_ref(input int m);
    int i = 0;
    while (i < AW && m[i] == 1'b0) i++;
    if (i > 2 || i == AW) return 1'b0;
    while (i < AW && m[i] == 1'b1) i++;
    while (i < AW) begin
      if (m[i]) return 1'b0;
      i++;
    end
    return 1'b1;
  endfunction

  // reference increment: pull out field, add, put back
  function automatic int inc_ref(input int c, input int m);
    int lo = 0;
    int w = 0;
    int f;
    while (m[lo] == 1'b0) lo++;
    for (int b = 0; b < AW; b++) w += m[b];
    f = ((c >> lo) & ((1 << w) - 1)) + 1;
    f = f % (1 << w);
    return (c & ~m & (N - 1)) | (f << lo);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int prev_mask;
    int cur;
    int start;
    int w;
    clr_in();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    chk("R1 addr", addr_out, 0);
    chk("R1 mask", mask_out, N - 1);
    chk("R1 irq_n", irq_n, 1);
    chk("R1 err", merr, 0);
    chk("R1 busy", busy_out, 0);

    // R4 every mask pattern
    prev_mask = N - 1;
    for (int m = 0; m < N; m++) begin
      mload = 1; addr_in = AW'(m);
      tick();
      if (valid_ref(m)) begin
        chk("R4 accept mask", mask_out, m);
        chk("R4 accept err", merr, 0);
        prev_mask = m;
      end else begin
        chk("R4 refuse keeps mask", mask_out, prev_mask);
        chk("R4 refuse err", merr, 1);
      end
    end
    tick();
    chk("R4 err clears", merr, 0);

    // R7 R8 R6 R3 R10 under every legal mask
    for (int m = 1; m < N; m++) begin
      if (!valid_ref(m)) continue;
      mload = 1; addr_in = AW'(m);
      tick();
      start = (m * 37 + 5) & (N - 1);
      cload = 1; addr_in = AW'(start);
      tick();
      chk("R3 load", addr_out, start);
      cur = start;
      w = 0;
      for (int b = 0; b < AW; b++) w += m[b];
      for (int s = 0; s <= (1 << w); s++) begin
        bit wrap;
        wrap = ((cur & m) == m);
        cinc = 1;
        tick();
        cur = inc_ref(cur, m);
        chk("R7 increment", addr_out, cur);
        chk("R8 irq", irq_n, wrap ? 0 : 1);
      end
      crst = 1;
      tick();
      cur = cur & ~m & (N - 1);
      chk("R6 clear field", addr_out, cur);
      tick();
      chk("R10 hold", addr_out, cur);
      retx = 1;
      tick();
      chk("R3 retransmit", addr_out, start);
      chk("R5 mask untouched", mask_out, m);
    end

    // R2 priority
    mrst_m = 1; tick();
    cload = 1; addr_in = 6'h15; tick();
    crst = 1; cload = 1; retx = 1; cinc = 1; addr_in = 6'h2A; tick();
    chk("R2 clear wins", addr_out, 0);
    cload = 1; retx = 1; cinc = 1; addr_in = 6'h2A; tick();
    chk("R2 load wins", addr_out, 6'h2A);
    cinc = 1; tick();
    chk("R2 inc alone", addr_out, 6'h2B);
    retx = 1; cinc = 1; tick();
    chk("R2 retx wins", addr_out, 6'h2A);
    mload = 1; addr_in = 6'h3C; tick();
    mrst = 1; cload = 1; crst = 1; mload = 1; addr_in = 6'h0C; tick();
    chk("R1 R2 master addr", addr_out, 0);
    chk("R1 R2 master mask", mask_out, N - 1);
    retx = 1; tick();
    chk("R1 mirror cleared", addr_out, 0);

    // R5 independence
    cload = 1; addr_in = 6'h0B; tick();
    mload = 1; addr_in = 6'h0C; tick();
    chk("R5 mask load", mask_out, 6'h0C);
    chk("R5 addr kept", addr_out, 6'h0B);
    cload = 1; addr_in = 6'h31; tick();
    chk("R5 mask kept", mask_out, 6'h0C);
    mrst_m = 1; tick();
    chk("R5 mask reset", mask_out, N - 1);
    chk("R5 addr kept2", addr_out, 6'h31);

    // R9 busy capture
    cload = 1; addr_in = 6'h27; tick();
    bcap = 1; cinc = 1; tick();
    chk("R9 busy pre-value", busy_out, 6'h27);
    chk("R9 addr advanced", addr_out, 6'h28);
    tick();
    chk("R9 busy held", busy_out, 6'h27);
    mrst = 1; tick();
    chk("R9 busy cleared", busy_out, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule